// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every request that can reset the device and turns each one into a timed reset sequence on two shared, wired-low reset lines. One line is the hard reset line and the other is the soft reset line. Power-on, a request seen on the external hard line, watchdog expiry, bus-monitor expiry and an enabled core checkstop each produce a hard sequence. A request seen on the external soft line and a test-port soft-reset request each produce a soft sequence. A hard sequence pulls both lines low and lets the soft line go a few cycles after the hard line. A soft sequence pulls only the soft line low.

The block never drives a line high. It drives one pull-down enable per line and reads each line back through an active-low pad input, so an external agent can also pull a line low. While the block is running a sequence of its own, it ignores all requests, including a low level on either line. A status register holds one bit for each source that started the most recent sequence. Software clears the bits by writing ones to them.

The power-on input is the block's synchronous active-low reset. The watchdog and bus-monitor counters are outside the block and supply only one-cycle expiry pulses. The pad inputs are expected to be synchronous to the clock already.

Top module: `rstctl_top`

## Requirements
- R1: While `rst_n` is low, both pull-down enables are 1 and `stat_q` reads 7'b0000001 (only the power-on bit, bit 0). After `rst_n` rises, `hard_pd_en` stays 1 for HOLD more cycles and `soft_pd_en` stays 1 for HOLD+TAIL more cycles, counting the cycle in which `rst_n` is first seen high.
- R2: Status bit positions are: bit 0 power-on, bit 1 external hard line, bit 2 external soft line, bit 3 watchdog, bit 4 bus monitor, bit 5 checkstop, bit 6 test-port soft request. Sources 1, 3, 4 and 5 are the hard class and sources 2 and 6 are the soft class. If any hard-class source is present, the sequence is hard.
- R3: A hard sequence begins in the cycle after the request is sampled. `hard_pd_en` is then 1 for exactly HOLD cycles and `soft_pd_en` for exactly HOLD+TAIL cycles, so the soft line is released TAIL cycles after the hard line.
- R4: A soft sequence holds `soft_pd_en` at 1 for exactly HOLD cycles and never raises `hard_pd_en`.
- R5: While `chk_rst_en` is 0, `core_chkstop` is ignored. It starts no sequence and sets no status bit.
- R6: While either pull-down enable is 1, every request is ignored. This includes a low level on either pad input. Such a request neither restarts nor extends the sequence, and it does not change `stat_q`.
- R7: When a sequence starts, `stat_q` is replaced by the set of all sources present in the start cycle. The power-on bit is cleared at that point.
- R8: Writing with `stat_clr_we` = 1 clears every `stat_q` bit whose `stat_clr_mask` bit is 1 and leaves the other bits alone. If a sequence starts in the same cycle, the new record wins.
- R9: The pull-down enables are active-high (1 = pull the line low), and `hard_pad_n` and `soft_pad_n` read the lines active-low. An external low level on an idle line starts that line's class of sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| hard_pad_n | input | 1 | Hard reset line level, low = asserted |
| soft_pad_n | input | 1 | Soft reset line level, low = asserted |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| bmon_expire | input | 1 | Bus-monitor expiry pulse |
| core_chkstop | input | 1 | Core checkstop indication |
| chk_rst_en | input | 1 | Mode bit: checkstop may reset |
| jtag_soft_req | input | 1 | Test-port soft-reset request |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 7 | Bits to clear (1 = clear) |
| stat_q | output | 7 | Cause record of last reset |
| hard_pd_en | output | 1 | Pull-down enable for the hard line |
| soft_pd_en | output | 1 | Pull-down enable for the soft line |

## Verification
The main sweep applies every combination of the six non-power-on sources as a single pulse, once with the checkstop enable at 0 and once at 1. This covers lone hard sources, lone soft sources, mixes of the two classes (which must give a hard sequence) and the empty set (which must leave the lines and the record alone). In each run the bench counts the cycles each line is held, checks the replaced record, and then clears a different mask per run to tell partial clears apart. Separate runs check three more cases. The first applies requests and line pulls while a sequence is active, which must change nothing. The second applies a power-on reset in the middle of a sequence. The third starts a sequence and clears the status in the same cycle.

// File: rtl/rstctl_pkg.sv
// Shared constants for the reset sequencer: source bit positions and class mask.
package rstctl_pkg;
    localparam int NSRC   = 7;
    localparam int B_POR  = 0;
    localparam int B_EXTH = 1;
    localparam int B_EXTS = 2;
    localparam int B_WDOG = 3;
    localparam int B_BMON = 4;
    localparam int B_CHK  = 5;
    localparam int B_JTAG = 6;

    typedef logic [NSRC-1:0] src_vec_t;

    // Sources that demand a hard sequence (bits 1, 3, 4, 5).
    localparam src_vec_t HARD_CLASS = src_vec_t'((1 << B_EXTH) | (1 << B_WDOG) |
                                                 (1 << B_BMON) | (1 << B_CHK));
endpackage

// File: rtl/rstctl_src.sv
// Request gathering and classification.
// Builds the source vector from the pads and internal events, masks the
// checkstop with its enable, suppresses everything while a sequence runs,
// and reports whether a start is due and which class it is.
// Assumes pad inputs are already synchronous to clk.
module rstctl_src
    import rstctl_pkg::*;
(
    input  logic     hard_pad_n,
    input  logic     soft_pad_n,
    input  logic     wdog_expire,
    input  logic     bmon_expire,
    input  logic     core_chkstop,
    input  logic     chk_rst_en,
    input  logic     jtag_soft_req,
    input  logic     busy,
    output src_vec_t req,
    output logic     start,
    output logic     start_hard
);
    src_vec_t raw;

    // Map each raw event onto its status bit position.
    always_comb begin
        raw         = '0;
        raw[B_EXTH] = ~hard_pad_n;
        raw[B_EXTS] = ~soft_pad_n;
        raw[B_WDOG] = wdog_expire;
        raw[B_BMON] = bmon_expire;
        raw[B_CHK]  = core_chkstop & chk_rst_en;
        raw[B_JTAG] = jtag_soft_req;
    end

    // Gate requests off while the controller is driving reset, then classify.
    always_comb begin
        req        = busy ? '0 : raw;
        start      = |req;
        start_hard = |(req & HARD_CLASS);
    end
endmodule

// File: rtl/rstctl_seq.sv
// Sequence timer.
// Runs a hard sequence (hard line HOLD cycles, soft line HOLD+TAIL cycles)
// or a soft sequence (soft line HOLD cycles). Power-on reset holds a hard
// sequence at its first count until released. Starts are accepted only
// when idle.
module rstctl_seq #(
    parameter int HOLD = 512,
    parameter int TAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_hard,
    output logic busy,
    output logic hard_en,
    output logic soft_en
);
    localparam int LONG = HOLD + TAIL;
    localparam int CW   = $clog2(LONG + 1);

    logic          is_hard;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last_cnt;

    // Final count value for the sequence in progress.
    always_comb last_cnt = is_hard ? CW'(LONG - 1) : CW'(HOLD - 1);

    // Sequence state: busy flag, class and elapsed-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b1;
            is_hard <= 1'b1;
            cnt     <= '0;
        end else if (busy) begin
            if (cnt == last_cnt) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end else if (start) begin
            busy    <= 1'b1;
            is_hard <= start_hard;
            cnt     <= '0;
        end
    end

    // Line enables: soft line for the whole sequence, hard line for the first HOLD cycles.
    always_comb begin
        soft_en = busy;
        hard_en = busy & is_hard & (cnt < CW'(HOLD));
    end
endmodule

// File: rtl/rstctl_stat.sv
// Reset cause record.
// Loads the full source vector when a sequence starts, otherwise clears
// bits written as one. Power-on leaves only the power-on bit set.
module rstctl_stat
    import rstctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rec,
    input  src_vec_t rec_vec,
    input  logic     clr_we,
    input  src_vec_t clr_mask,
    output src_vec_t stat
);
    // Record on start (takes precedence), else write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat <= src_vec_t'(1 << B_POR);
        else if (rec)    stat <= rec_vec;
        else if (clr_we) stat <= stat & ~clr_mask;
    end
endmodule

// File: rtl/rstctl_top.sv
// Multi-source reset sequencer top.
// Connects request gathering, the sequence timer and the cause record.
// Outputs are open-drain pull-down enables; the pad inputs read the lines back.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int HOLD = 512,
    parameter int TAIL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hard_pad_n,
    input  logic            soft_pad_n,
    input  logic            wdog_expire,
    input  logic            bmon_expire,
    input  logic            core_chkstop,
    input  logic            chk_rst_en,
    input  logic            jtag_soft_req,
    input  logic            stat_clr_we,
    input  logic [NSRC-1:0] stat_clr_mask,
    output logic [NSRC-1:0] stat_q,
    output logic            hard_pd_en,
    output logic            soft_pd_en
);
    src_vec_t req;
    logic     start;
    logic     start_hard;
    logic     busy;

    rstctl_src u_src (
        .hard_pad_n   (hard_pad_n),
        .soft_pad_n   (soft_pad_n),
        .wdog_expire  (wdog_expire),
        .bmon_expire  (bmon_expire),
        .core_chkstop (core_chkstop),
        .chk_rst_en   (chk_rst_en),
        .jtag_soft_req(jtag_soft_req),
        .busy         (busy),
        .req          (req),
        .start        (start),
        .start_hard   (start_hard)
    );

    rstctl_seq #(.HOLD(HOLD), .TAIL(TAIL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_hard(start_hard),
        .busy      (busy),
        .hard_en   (hard_pd_en),
        .soft_en   (soft_pd_en)
    );

    rstctl_stat u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rec     (start),
        .rec_vec (req),
        .clr_we  (stat_clr_we),
        .clr_mask(stat_clr_mask),
        .stat    (stat_q)
    );
endmodule

// File: rtl/rstctl_chk.sv
// Property checker for rstctl_top, attached by bind.
// Assumes the pad inputs reflect the pull-down enables (wired-low lines).
module rstctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hard_pad_n,
    input logic       soft_pad_n,
    input logic       wdog_expire,
    input logic       bmon_expire,
    input logic       core_chkstop,
    input logic       chk_rst_en,
    input logic       jtag_soft_req,
    input logic       stat_clr_we,
    input logic [6:0] stat_q,
    input logic       hard_pd_en,
    input logic       soft_pd_en
);
    logic hard_src;
    always_comb hard_src = wdog_expire | bmon_expire | (core_chkstop & chk_rst_en) | ~hard_pad_n;

    // R3: the soft line is held whenever the hard line is held.
    assert_soft_covers_hard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hard_pd_en |-> soft_pd_en);

    // R3: the hard line is released before the soft line.
    assert_soft_released_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_pd_en) |-> soft_pd_en);

    // R2: a watchdog expiry while idle starts a hard sequence.
    assert_wdog_hard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_pd_en && wdog_expire) |=> hard_pd_en);

    // R4: a test-port request with no hard source starts a soft-only sequence.
    assert_jtag_soft_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_pd_en && jtag_soft_req && !hard_src) |=> (soft_pd_en && !hard_pd_en));

    // R5: a masked checkstop alone starts nothing.
    assert_chk_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_pd_en && core_chkstop && !chk_rst_en && !wdog_expire && !bmon_expire &&
         !jtag_soft_req && hard_pad_n && soft_pad_n) |=> !soft_pd_en);

    // R6: while a sequence runs, the record changes only through a clear write.
    assert_record_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_pd_en && !stat_clr_we) |=> $stable(stat_q));
endmodule

bind rstctl_top rstctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hard_pad_n   (hard_pad_n),
    .soft_pad_n   (soft_pad_n),
    .wdog_expire  (wdog_expire),
    .bmon_expire  (bmon_expire),
    .core_chkstop (core_chkstop),
    .chk_rst_en   (chk_rst_en),
    .jtag_soft_req(jtag_soft_req),
    .stat_clr_we  (stat_clr_we),
    .stat_q       (stat_q),
    .hard_pd_en   (hard_pd_en),
    .soft_pd_en   (soft_pd_en)
);

// File: tb/rstctl_top_test.sv
// Self-checking bench: sweeps every source combination on a short-timer configuration.
module rstctl_top_test;
    localparam int HOLD = 8;
    localparam int TAIL = 3;
    localparam int LONG = HOLD + TAIL;
    localparam logic [6:0] HCLS = 7'b0111010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_hard = 1'b0, ext_soft = 1'b0;
    logic       wdog_expire = 1'b0, bmon_expire = 1'b0, core_chkstop = 1'b0;
    logic       chk_rst_en = 1'b0, jtag_soft_req = 1'b0, stat_clr_we = 1'b0;
    logic [6:0] stat_clr_mask = '0;
    logic [6:0] stat_q;
    logic       hard_pd_en, soft_pd_en;
    wire        hard_pad_n = ~(hard_pd_en | ext_hard);
    wire        soft_pad_n = ~(soft_pd_en | ext_soft);

    int checks = 0, failures = 0, cycles = 0;
    logic [6:0] model;

    rstctl_top #(.HOLD(HOLD), .TAIL(TAIL)) uut (
        .clk(clk), .rst_n(rst_n), .hard_pad_n(hard_pad_n), .soft_pad_n(soft_pad_n),
        .wdog_expire(wdog_expire), .bmon_expire(bmon_expire), .core_chkstop(core_chkstop),
        .chk_rst_en(chk_rst_en), .jtag_soft_req(jtag_soft_req), .stat_clr_we(stat_clr_we),
        .stat_clr_mask(stat_clr_mask), .stat_q(stat_q),
        .hard_pd_en(hard_pd_en), .soft_pd_en(soft_pd_en));

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts cycles each enable is held over a window starting at the current negedge.
    task automatic measure(output int hc, output int sc);
        hc = 0; sc = 0;
        for (int i = 0; i < LONG + 4; i++) begin
            hc += int'(hard_pd_en);
            sc += int'(soft_pd_en);
            @(negedge clk);
        end
    endtask

    task automatic drive(input logic [6:0] m);
        ext_hard      = m[1];
        ext_soft      = m[2];
        wdog_expire   = m[3];
        bmon_expire   = m[4];
        core_chkstop  = m[5];
        jtag_soft_req = m[6];
    endtask

    initial begin
        int hc, sc;
        // R1: state during power-on, then the hard sequence after release.
        repeat (3) @(negedge clk);
        check("R1 hard_pd_en in reset", int'(hard_pd_en), 1);
        check("R1 soft_pd_en in reset", int'(soft_pd_en), 1);
        check("R1 stat in reset", int'(stat_q), 1);
        rst_n = 1'b1;
        measure(hc, sc);
        check("R1 hard hold after release", hc, HOLD);
        check("R1 soft hold after release", sc, LONG);
        model = 7'b0000001;

        // R2 R3 R4 R5 R7 R8 R9: sweep every source set with checkstop enable off and on.
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 64; m++) begin
                logic [6:0] src, eff, clrm;
                logic       hard;
                src  = 7'(m << 1);
                eff  = en != 0 ? src : (src & ~7'b0100000);
                hard = |(eff & HCLS);
                chk_rst_en = en[0];
                drive(src);
                @(negedge clk);
                drive('0);
                measure(hc, sc);
                check("R3 R9 hard line cycles", hc, hard ? HOLD : 0);
                check("R2 R4 R5 soft line cycles", sc, (eff == 0) ? 0 : (hard ? LONG : HOLD));
                if (eff != 0) model = eff;
                check("R7 R5 status record", int'(stat_q), int'(model));
                clrm = 7'((m * 37) ^ (en * 85));
                stat_clr_we = 1'b1; stat_clr_mask = clrm;
                @(negedge clk);
                stat_clr_we = 1'b0;
                model = model & ~clrm;
                check("R8 partial clear", int'(stat_q), int'(model));
            end
        end

        // R6: requests and line pulls during a soft sequence are ignored.
        jtag_soft_req = 1'b1;
        @(negedge clk);
        jtag_soft_req = 1'b0;
        hc = int'(hard_pd_en); sc = int'(soft_pd_en);
        @(negedge clk); hc += int'(hard_pd_en); sc += int'(soft_pd_en);
        wdog_expire = 1'b1; ext_hard = 1'b1; ext_soft = 1'b1; bmon_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0; bmon_expire = 1'b0; ext_hard = 1'b0;
        hc += int'(hard_pd_en); sc += int'(soft_pd_en);
        @(negedge clk);
        ext_soft = 1'b0;
        for (int i = 0; i < LONG + 2; i++) begin
            hc += int'(hard_pd_en); sc += int'(soft_pd_en);
            @(negedge clk);
        end
        check("R6 no hard during soft sequence", hc, 0);
        check("R6 soft sequence not extended", sc, HOLD);
        check("R6 status unchanged", int'(stat_q), 7'h40);

        // R8: start and clear in the same cycle, record wins.
        wdog_expire = 1'b1; stat_clr_we = 1'b1; stat_clr_mask = 7'h7f;
        @(negedge clk);
        wdog_expire = 1'b0; stat_clr_we = 1'b0;
        check("R8 record beats clear", int'(stat_q), 7'h08);
        repeat (LONG + 2) @(negedge clk);

        // R1: power-on in the middle of a soft sequence.
        jtag_soft_req = 1'b1;
        @(negedge clk);
        jtag_soft_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-sequence reset hard", int'(hard_pd_en), 1);
        check("R1 mid-sequence reset stat", int'(stat_q), 1);
        rst_n = 1'b1;
        measure(hc, sc);
        check("R1 hard hold after mid reset", hc, HOLD);
        check("R1 soft hold after mid reset", sc, LONG);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule